// File: doc/BRIEF.md
# Indirect Configuration Table Access Controller

This block lets a host reach three internal configuration tables through a small register space: a table of scheme entries (23 words each), a table of port partition entries (two words each) and a table of classification-plan entries (a parameterised number of words each). The tables sit in internal RAM and are not directly addressable. The host stages data in a shared window of data registers and then writes one command word to the action register. The command names the target table, the entry index, the direction and which words to move.

While the command runs, the controller moves one word per cycle between the window and the chosen entry. The GO bit stays set for the whole operation, so the host polls the action register until GO reads 0 and then reads the error flag. A command that names a bad target or an index past the end of its table is refused at once. It sets the error flag and changes no storage.

Top module: `idx_tbl_ctrl`

## Requirements
- R1: After synchronous reset the action register reads 0 and every window word reads 0.
- R2: A write command (bit 30 = 0) copies window word k into word k of the selected entry. GO (bit 31) reads 1 for N+1 cycles after the accepting edge and 0 after that. N is 23 for a scheme entry, 2 for a port entry and CP_WORDS for a plan entry.
- R3: A read command (bit 30 = 1) copies word k of the selected entry into window word k. The new data is in the window once GO reads 0.
- R4: While GO is set, host writes to the window or to the action register have no effect. At any time, an action write with bit 31 clear has no effect.
- R5: Target select bits 25:24 equal to 11 set the error flag (bit 29), leave GO at 0 and move no data.
- R6: An index at or above the size of its table sets the error flag, leaves GO at 0 and moves no data. The scheme and plan index is in bits 21:16. The port index is in bits 7:0.
- R7: For a port entry, bit 15 selects the scheme-partition word (window word 0) and bit 14 selects the plan-partition word (window word 1). A word that is not selected is left untouched, both in the table and in the window.
- R8: On a scheme write with bit 15 clear, the stored counter word (word 16) keeps its value. With bit 15 set, word 16 is written like every other word.
- R9: An accepted valid command clears the error flag left by an earlier refused command.
- R10: Target code 00 selects the scheme table, 10 the port table and 01 the plan table. Window word i is at byte offset 0x100+4i. The action register is at byte offset 0x1FC. Register reads return their data on the edge after bus_rd, and unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 7 | Word address, byte offset bits 8:2 |
| bus_wr | input | 1 | Register write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Register read strobe |
| bus_rdata | output | 32 | Registered read data |

## Verification
The bench builds the block with 32 schemes, 64 ports and only 4 plan entries of 8 words. With these sizes the 6-bit scheme and plan index field and the 8-bit port field both hold out-of-range values, so the refusal path can be reached in every table. The largest legal indices (scheme 31, port 63, plan 3) are also used, which exercises the last rows of each RAM.

// File: rtl/idx_tbl_pkg.sv
package idx_tbl_pkg;
  typedef enum logic [1:0] {
    TGT_SCH = 2'b00,
    TGT_CPL = 2'b01,
    TGT_PRT = 2'b10,
    TGT_BAD = 2'b11
  } tgt_e;

  localparam int SCH_WORDS = 23;
  localparam int CNT_WORD  = 16;
  localparam int PRT_WORDS = 2;
  localparam int B_GO  = 31;
  localparam int B_RD  = 30;
  localparam int B_ERR = 29;
endpackage

// File: rtl/idx_tbl_decode.sv
module idx_tbl_decode
  import idx_tbl_pkg::*;
#(
  parameter int NUM_SCH  = 32,
  parameter int NUM_PORT = 64,
  parameter int NUM_CP   = 4,
  parameter int CP_WORDS = 8,
  parameter int CW       = 5
) (
  input  logic [1:0]    sel,
  input  logic [5:0]    tidx,
  input  logic [7:0]    pidx,
  output logic [7:0]    idx,
  output logic          bad,
  output logic [CW-1:0] last
);
  always_comb begin
    idx  = {2'b00, tidx};
    bad  = 1'b0;
    last = CW'(SCH_WORDS);
    case (tgt_e'(sel))
      TGT_SCH: bad = (int'(tidx) >= NUM_SCH);
      TGT_PRT: begin
        idx  = pidx;
        bad  = (int'(pidx) >= NUM_PORT);
        last = CW'(PRT_WORDS);
      end
      TGT_CPL: begin
        bad  = (int'(tidx) >= NUM_CP);
        last = CW'(CP_WORDS);
      end
      default: bad = 1'b1;
    endcase
  end
endmodule

// File: rtl/idx_tbl_ram.sv
module idx_tbl_ram #(
  parameter int DW    = 32,
  parameter int DEPTH = 64,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

  p_addr_range_r6: assert property (@(posedge clk) we |-> (int'(waddr) < DEPTH))
    else $error("table write outside its RAM");
endmodule

// File: rtl/idx_tbl_ctrl.sv
module idx_tbl_ctrl
  import idx_tbl_pkg::*;
#(
  parameter int NUM_SCH  = 32,
  parameter int NUM_PORT = 64,
  parameter int NUM_CP   = 4,
  parameter int CP_WORDS = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [8:2]  bus_addr,
  input  logic        bus_wr,
  input  logic [31:0] bus_wdata,
  input  logic        bus_rd,
  output logic [31:0] bus_rdata
);
  localparam int WIN_WORDS = (CP_WORDS > SCH_WORDS) ? CP_WORDS : SCH_WORDS;
  localparam int WAW  = $clog2(WIN_WORDS);
  localparam int CW   = $clog2(WIN_WORDS + 1);
  localparam int SDEP = NUM_SCH * SCH_WORDS;
  localparam int PDEP = NUM_PORT * PRT_WORDS;
  localparam int CDEP = NUM_CP * CP_WORDS;
  localparam int SAW  = $clog2(SDEP);
  localparam int PAW  = $clog2(PDEP);
  localparam int CAW  = $clog2(CDEP);

  logic [31:0]   win [WIN_WORDS];
  logic          busy, err, act_rd;
  logic [28:0]   act_lo;
  logic [CW-1:0] cnt, op_last;
  logic [7:0]    op_idx;
  logic          rd_v;
  logic [WAW-1:0] rd_k;
  tgt_e          rd_t;

  // host side decode
  logic       hit_win, hit_act, start;
  logic [5:0] wi;
  assign wi      = bus_addr[7:2];
  assign hit_win = bus_addr[8] && (int'(wi) < WIN_WORDS);
  assign hit_act = (bus_addr == 7'h7F);
  assign start   = bus_wr && hit_act && !busy && bus_wdata[B_GO];

  logic [7:0]    dec_idx;
  logic          dec_bad;
  logic [CW-1:0] dec_last;
  idx_tbl_decode #(.NUM_SCH(NUM_SCH), .NUM_PORT(NUM_PORT), .NUM_CP(NUM_CP),
                   .CP_WORDS(CP_WORDS), .CW(CW)) u_dec (
    .sel(bus_wdata[25:24]), .tidx(bus_wdata[21:16]), .pidx(bus_wdata[7:0]),
    .idx(dec_idx), .bad(dec_bad), .last(dec_last));

  // sequencer
  tgt_e op_tgt;
  assign op_tgt = tgt_e'(act_lo[25:24]);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0; err <= 1'b0; act_rd <= 1'b0; act_lo <= '0;
      cnt <= '0; op_last <= '0; op_idx <= '0;
    end else if (start) begin
      act_rd <= bus_wdata[B_RD];
      act_lo <= bus_wdata[28:0];
      err    <= dec_bad;
      busy   <= !dec_bad;
      cnt    <= '0;
      op_last <= dec_last;
      op_idx <= dec_idx;
    end else if (busy) begin
      if (cnt == op_last) busy <= 1'b0;
      cnt <= cnt + 1'b1;
    end
  end

  logic step, word_en;
  always_comb begin
    step = busy && (cnt < op_last);
    case (op_tgt)
      TGT_SCH: word_en = act_rd || (int'(cnt) != CNT_WORD) || act_lo[15];
      TGT_PRT: word_en = (cnt == '0) ? act_lo[15] : act_lo[14];
      default: word_en = 1'b1;
    endcase
  end

  logic           mv;
  logic           we_s, we_p, we_c;
  logic [SAW-1:0] a_s;
  logic [PAW-1:0] a_p;
  logic [CAW-1:0] a_c;
  logic [31:0]    q_s, q_p, q_c, wword;
  assign mv    = step && word_en;
  assign wword = win[cnt[WAW-1:0]];
  assign we_s  = mv && !act_rd && (op_tgt == TGT_SCH);
  assign we_p  = mv && !act_rd && (op_tgt == TGT_PRT);
  assign we_c  = mv && !act_rd && (op_tgt == TGT_CPL);
  assign a_s   = SAW'(int'(op_idx) * SCH_WORDS + int'(cnt));
  assign a_p   = PAW'(int'(op_idx) * PRT_WORDS + int'(cnt));
  assign a_c   = CAW'(int'(op_idx) * CP_WORDS + int'(cnt));

  idx_tbl_ram #(.DW(32), .DEPTH(SDEP)) u_sch (
    .clk(clk), .we(we_s), .waddr(a_s), .wdata(wword), .raddr(a_s), .rdata(q_s));
  idx_tbl_ram #(.DW(32), .DEPTH(PDEP)) u_prt (
    .clk(clk), .we(we_p), .waddr(a_p), .wdata(wword), .raddr(a_p), .rdata(q_p));
  idx_tbl_ram #(.DW(32), .DEPTH(CDEP)) u_cpl (
    .clk(clk), .we(we_c), .waddr(a_c), .wdata(wword), .raddr(a_c), .rdata(q_c));

  // table read pipeline: RAM data lands one cycle after its address
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_v <= 1'b0; rd_k <= '0; rd_t <= TGT_SCH;
    end else begin
      rd_v <= mv && act_rd;
      rd_k <= cnt[WAW-1:0];
      rd_t <= op_tgt;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < WIN_WORDS; i++) win[i] <= '0;
    end else if (rd_v) begin
      case (rd_t)
        TGT_SCH: win[rd_k] <= q_s;
        TGT_PRT: win[rd_k] <= q_p;
        default: win[rd_k] <= q_c;
      endcase
    end else if (bus_wr && hit_win && !busy) begin
      win[wi[WAW-1:0]] <= bus_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else if (bus_rd) begin
      if (hit_act)      bus_rdata <= {busy, act_rd, err, act_lo};
      else if (hit_win) bus_rdata <= win[wi[WAW-1:0]];
      else              bus_rdata <= '0;
    end
  end

  p_err_idle_r5: assert property (@(posedge clk) disable iff (rst) err |-> !busy)
    else $error("error flag with GO set");
  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (rst) busy |-> (cnt <= op_last))
    else $error("step counter past end");
  p_go_len_r2: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> ($past(cnt) == $past(op_last)))
    else $error("GO cleared early");
  p_hold_act_r4: assert property (@(posedge clk) disable iff (rst)
    (busy && bus_wr && hit_act) |=> ($stable(act_lo) && $stable(act_rd)))
    else $error("command changed while busy");
  p_one_table_r7: assert property (@(posedge clk) disable iff (rst) $onehot0({we_s, we_p, we_c}))
    else $error("two tables written at once");
  p_no_win_wr_r4: assert property (@(posedge clk) disable iff (rst)
    (busy && !rd_v) |=> $stable(win[0]))
    else $error("window changed by host while busy");
endmodule

// File: tb/sim_idx_tbl_ctrl.sv
module sim_idx_tbl_ctrl;
  localparam int NS = 32, NP = 64, NC = 4, CWD = 8, SW = 23, WW = 23;
  localparam logic [8:0] ACT = 9'h1FC;

  logic clk = 1'b0, rst = 1'b1;
  logic [8:0]  bus_a = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  int vecs = 0, fails = 0;

  always #4 clk = ~clk;

  idx_tbl_ctrl #(.NUM_SCH(NS), .NUM_PORT(NP), .NUM_CP(NC), .CP_WORDS(CWD)) u0 (
    .clk(clk), .rst(rst), .bus_addr(bus_a[8:2]), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata));

  // behavioural reference model
  logic [31:0] sch_m [NS][SW];
  logic [31:0] prt_m [NP][2];
  logic [31:0] cp_m  [NC][CWD];
  logic [31:0] win_m [WW];
  logic [31:0] act_m;
  logic        err_m;
  int          left;

  function automatic logic [31:0] mrd(input logic [8:0] a);
    if (a == ACT) return {left > 0, act_m[30], err_m, act_m[28:0]};
    if (a[8] && int'(a[7:2]) < WW) return win_m[a[7:2]];
    return 32'h0;
  endfunction

  task automatic mexec(input logic [31:0] c);
    int n = 0;
    bit bad = 0;
    int ti = int'(c[21:16]);
    int pi = int'(c[7:0]);
    act_m = c;
    case (c[25:24])
      2'b00: if (ti >= NS) bad = 1; else begin
        n = SW;
        for (int k = 0; k < SW; k++)
          if (c[30]) win_m[k] = sch_m[ti][k];
          else if (k != 16 || c[15]) sch_m[ti][k] = win_m[k];
      end
      2'b10: if (pi >= NP) bad = 1; else begin
        n = 2;
        for (int k = 0; k < 2; k++)
          if ((k == 0) ? c[15] : c[14]) begin
            if (c[30]) win_m[k] = prt_m[pi][k]; else prt_m[pi][k] = win_m[k];
          end
      end
      2'b01: if (ti >= NC) bad = 1; else begin
        n = CWD;
        for (int k = 0; k < CWD; k++)
          if (c[30]) win_m[k] = cp_m[ti][k]; else cp_m[ti][k] = win_m[k];
      end
      default: bad = 1;
    endcase
    err_m = bad;
    left  = bad ? 0 : n + 1;
  endtask

  task automatic cyc(input logic wr, input logic rd, input logic [8:0] a,
                     input logic [31:0] d, input string tag);
    logic [31:0] exp;
    bus_wr = wr; bus_rd = rd; bus_a = a; bus_wdata = d;
    exp = mrd(a);
    @(posedge clk);
    if (left > 0) left--;
    else if (wr) begin
      if (a == ACT) begin if (d[31]) mexec(d); end
      else if (a[8] && int'(a[7:2]) < WW) win_m[a[7:2]] = d;
    end
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0;
    if (rd) begin
      vecs++;
      if (bus_rdata !== exp) begin
        fails++;
        $display("FAIL %s addr=%h actual=%h expected=%h", tag, a, bus_rdata, exp);
      end
    end
  endtask

  task automatic wr_win(input int i, input logic [31:0] d, input string tag);
    cyc(1'b1, 1'b0, 9'h100 + 9'(4 * i), d, tag);
  endtask

  task automatic chk_win(input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(1'b0, 1'b1, 9'h100 + 9'(4 * i), '0, tag);
  endtask

  task automatic run_op(input logic [31:0] c, input string tag);
    cyc(1'b1, 1'b0, ACT, c, tag);
    for (int g = 0; g < 100 && left > 0; g++) cyc(1'b0, 1'b1, ACT, '0, tag);
    cyc(1'b0, 1'b1, ACT, '0, tag);
  endtask

  function automatic logic [31:0] cmd(input bit rd, input logic [1:0] sel,
                                      input int ti, input int pi, input bit b15, input bit b14);
    return {1'b1, rd, 4'b0, sel, 2'b0, 6'(ti), b15, b14, 6'b0, 8'(pi)};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < WW; i++) win_m[i] = '0;
    act_m = '0; err_m = 1'b0; left = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    cyc(1'b0, 1'b1, ACT, '0, "R1");
    chk_win(WW, "R1");
    cyc(1'b0, 1'b1, 9'h0C0, '0, "R10");
    // R2 scheme write with counter update, largest index
    for (int i = 0; i < SW; i++) wr_win(i, 32'hA500_0000 + 32'(i), "R2");
    run_op(cmd(0, 2'b00, 31, 0, 1, 0), "R2");
    run_op(cmd(0, 2'b00, 5, 0, 1, 0), "R2");
    // R3 read back into a cleared window
    for (int i = 0; i < SW; i++) wr_win(i, 32'h0, "R3");
    run_op(cmd(1, 2'b00, 31, 0, 0, 0), "R3");
    chk_win(SW, "R3");
    // R8 counter word kept when update bit clear
    for (int i = 0; i < SW; i++) wr_win(i, 32'h5A00_0100 + 32'(i), "R8");
    run_op(cmd(0, 2'b00, 5, 0, 0, 0), "R8");
    for (int i = 0; i < SW; i++) wr_win(i, 32'h0, "R8");
    run_op(cmd(1, 2'b00, 5, 0, 0, 0), "R8");
    chk_win(SW, "R8");
    // R7 port partition word selects
    wr_win(0, 32'h8000_0001, "R7"); wr_win(1, 32'h0000_00C3, "R7");
    run_op(cmd(0, 2'b10, 0, 63, 1, 1), "R7");
    wr_win(0, 32'h4000_0000, "R7"); wr_win(1, 32'hDEAD_BEEF, "R7");
    run_op(cmd(0, 2'b10, 0, 63, 1, 0), "R7");
    wr_win(0, 32'h1111_1111, "R7"); wr_win(1, 32'h2222_2222, "R7");
    run_op(cmd(1, 2'b10, 0, 63, 0, 1), "R7");
    chk_win(2, "R7");
    run_op(cmd(1, 2'b10, 0, 63, 1, 1), "R7");
    chk_win(2, "R7");
    // R10 plan table, target code 01
    for (int i = 0; i < CWD; i++) wr_win(i, 32'hC0DE_0000 + 32'(i * 3), "R10");
    run_op(cmd(0, 2'b01, 3, 0, 0, 0), "R10");
    for (int i = 0; i < CWD; i++) wr_win(i, 32'h0, "R10");
    run_op(cmd(1, 2'b01, 3, 0, 0, 0), "R10");
    chk_win(CWD, "R10");
    // R5 bad target code
    run_op(cmd(1, 2'b11, 0, 0, 0, 0), "R5");
    chk_win(4, "R5");
    // R9 valid command clears the flag
    run_op(cmd(1, 2'b01, 3, 0, 0, 0), "R9");
    // R6 out-of-range indices in each table
    run_op(cmd(1, 2'b00, 40, 0, 0, 0), "R6");
    run_op(cmd(0, 2'b10, 0, 64, 1, 1), "R6");
    run_op(cmd(1, 2'b01, 4, 0, 0, 0), "R6");
    run_op(cmd(1, 2'b10, 0, 200, 1, 1), "R6");
    chk_win(SW, "R6");
    run_op(cmd(1, 2'b00, 5, 0, 0, 0), "R9");
    // R4 host writes ignored while busy, and bit-31-clear command ignored
    wr_win(0, 32'h7777_0000, "R4");
    cyc(1'b1, 1'b0, ACT, cmd(0, 2'b00, 7, 0, 1, 0), "R4");
    wr_win(0, 32'hBAD0_BAD0, "R4");
    cyc(1'b1, 1'b0, ACT, cmd(0, 2'b11, 0, 0, 0, 0), "R4");
    for (int g = 0; g < 100 && left > 0; g++) cyc(1'b0, 1'b1, ACT, '0, "R4");
    cyc(1'b0, 1'b1, ACT, '0, "R4");
    chk_win(2, "R4");
    cyc(1'b1, 1'b0, ACT, 32'h0100_0003, "R4");
    cyc(1'b0, 1'b1, ACT, '0, "R4");
    for (int i = 0; i < SW; i++) wr_win(i, 32'h0, "R4");
    run_op(cmd(1, 2'b00, 7, 0, 0, 0), "R4");
    chk_win(SW, "R4");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end
endmodule